// File: doc/BRIEF.md
# SD Card SPI-Mode Bring-Up Sequencer

This block takes a memory card from power-up into its serial (SPI) operating mode and works out which generation and capacity class the card belongs to. It does not shift bytes itself. Instead it hands one request at a time to a separate command engine: either a burst of idle clocks, or a framed command with index, argument, check byte and an optional four-byte tail. It then steers the flow from the first response byte (and the tail, where there is one) that the engine returns.

A one-cycle `start` pulse runs the whole sequence. These steps run in a fixed order: idle clocking, software reset, interface-condition check, a bounded loop of application-command prefix plus operating-condition request, an operating-conditions read on second-generation cards, and a block-length setup. While the sequence runs, `clk_fast` stays low so that the engine uses its slow divider. After a successful finish it goes high to select the data-rate divider. The result is held on `done`/`error` and `card_type` until the next start.

Top module: `sdi_init_seq`

## Requirements
- R1: A `start` pulse while idle raises `busy` on the next cycle and begins the sequence. A `start` while `busy` is high has no effect on the request order or the outcome, and this includes a start in the same cycle as the final acknowledge.
- R2: The first request of every run is an idle-clock burst (`eng_idle_clk`=1, chip select left deasserted by the engine) of `WAKE_BYTES` (default 16) bytes.
- R3: The reset command has index 0, argument 0 and check byte 0x95. Its response byte must equal exactly 0x01, and any other value ends the run as failed.
- R4: The interface-check command has index 8, argument 0x000001AA, check byte 0x87 and `eng_long`=1. A response of 0x01 selects the second-generation flow, 0x05 selects the first-generation flow, and anything else fails.
- R5: Initialization repeats index 55 (argument 0) followed by index 41 (argument 0), each with check byte 0xFF, until index 41 answers 0x00. The value answered to index 55 is ignored.
- R6: At most `MAX_TRIES` index-41 attempts are made. A non-zero answer to the last permitted attempt fails the run, and success on that attempt does not.
- R7: Only in the second-generation flow, a successful index 41 is followed by index 58 with `eng_long`=1. Bit 30 of the returned 32-bit word set means high capacity, and the other bits are ignored.
- R8: Identification ends with index 16, argument `BLOCK_BYTES` (default 512), check byte 0xFF. A non-zero response fails the run.
- R9: `clk_fast` is low from reset and from every accepted start. It rises only together with `done` after a successful block-length step, and stays high until the next start.
- R10: Exactly one of `done`/`error` rises when a run ends, and it holds until the next start. `card_type` is 0 on failure, 1 for first generation, 2 for second-generation standard capacity, and 3 for second-generation high capacity.
- R11: An acknowledge carrying `eng_nores`=1 on any command fails the run.
- R12: `eng_req` stays high with stable request fields until `eng_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous-free synchronous reset |
| start | input | 1 | Begin a bring-up run (accepted only when idle) |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last run ended successfully (held) |
| error | output | 1 | Last run failed (held) |
| card_type | output | 2 | 0 fail, 1 gen-1, 2 gen-2 standard, 3 gen-2 high capacity |
| clk_fast | output | 1 | 0 selects the slow divider, 1 the data-rate divider |
| eng_req | output | 1 | Request to the command engine |
| eng_idle_clk | output | 1 | Request is an idle-clock burst with chip select high |
| eng_idle_bytes | output | $clog2(WAKE_BYTES+1) | Byte count of the idle burst |
| eng_cmd | output | 6 | Command index |
| eng_arg | output | 32 | Command argument |
| eng_crc | output | 8 | Check/end byte of the command frame |
| eng_long | output | 1 | Four response bytes follow the first one |
| eng_ack | input | 1 | One-cycle completion of the pending request |
| eng_r1 | input | 8 | First response byte, valid with `eng_ack` |
| eng_nores | input | 1 | No response arrived, valid with `eng_ack` |
| eng_ocr | input | 32 | Four-byte response tail, valid with `eng_ack` |

## Verification
The one collision this block can meet is a new `start` landing in the very cycle that the engine acknowledges the final step, so that the completion edge and the launch edge coincide. The bench provokes it by raising `start` in the same cycle as the terminal acknowledge. It judges that `done` or `error` rises and that `busy` stays low. No further request may appear, because any unexpected request is reported against the scripted order. A cycle-accurate behavioural model compares the flags on every clock. A second case holds `start` high during the first cycles of a run, and the model checks that the request order stays the same.

// File: rtl/sdi_pkg.sv
package sdi_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WAKE,
      ST_RESET,
      ST_IFCOND,
      ST_APPCMD,
      ST_OPCOND,
      ST_READOCR,
      ST_BLKLEN
   } sdi_step_e;

   typedef enum logic [1:0] {
      VD_NEXT,   // proceed on the main path
      VD_ALT,    // proceed on the alternate (first-generation) path
      VD_RETRY,  // repeat the initialization pair
      VD_FAIL    // abort the run
   } sdi_verdict_e;

   typedef enum logic [1:0] {
      TYPE_NONE = 2'd0,
      TYPE_V1   = 2'd1,
      TYPE_V2SC = 2'd2,
      TYPE_V2HC = 2'd3
   } sdi_type_e;

   typedef struct packed {
      logic        dummy;
      logic [5:0]  idx;
      logic [31:0] arg;
      logic [7:0]  crc;
      logic        long_rsp;
   } sdi_req_t;

   localparam logic [5:0] IDX_SWRESET = 6'd0;
   localparam logic [5:0] IDX_IFCHECK = 6'd8;
   localparam logic [5:0] IDX_SETBLK  = 6'd16;
   localparam logic [5:0] IDX_OPINIT  = 6'd41;
   localparam logic [5:0] IDX_APPPRE  = 6'd55;
   localparam logic [5:0] IDX_RDCOND  = 6'd58;

   localparam logic [31:0] IFCHECK_ARG = 32'h0000_01AA;
   localparam logic [7:0]  CRC_SWRESET = 8'h95;
   localparam logic [7:0]  CRC_IFCHECK = 8'h87;
   localparam logic [7:0]  CRC_FILLER  = 8'hFF;

   localparam logic [7:0] RSP_IDLE_ONLY    = 8'h01;
   localparam logic [7:0] RSP_IDLE_ILLEGAL = 8'h05;
   localparam logic [7:0] RSP_READY        = 8'h00;

endpackage

// File: rtl/sdi_req_gen.sv
module sdi_req_gen
   import sdi_pkg::*;
#(
   parameter int BLOCK_BYTES = 512
) (
   input  sdi_step_e step,
   output sdi_req_t  req
);

   localparam logic [31:0] BLK_ARG = 32'(BLOCK_BYTES);

   always_comb begin
      req = '0;
      unique case (step)
         ST_WAKE: begin
            req.dummy = 1'b1;
         end
         ST_RESET: begin
            req.idx = IDX_SWRESET;
            req.crc = CRC_SWRESET;
         end
         ST_IFCOND: begin
            req.idx      = IDX_IFCHECK;
            req.arg      = IFCHECK_ARG;
            req.crc      = CRC_IFCHECK;
            req.long_rsp = 1'b1;
         end
         ST_APPCMD: begin
            req.idx = IDX_APPPRE;
            req.crc = CRC_FILLER;
         end
         ST_OPCOND: begin
            req.idx = IDX_OPINIT;
            req.crc = CRC_FILLER;
         end
         ST_READOCR: begin
            req.idx      = IDX_RDCOND;
            req.crc      = CRC_FILLER;
            req.long_rsp = 1'b1;
         end
         ST_BLKLEN: begin
            req.idx = IDX_SETBLK;
            req.arg = BLK_ARG;
            req.crc = CRC_FILLER;
         end
         default: req = '0;
      endcase
   end

endmodule

// File: rtl/sdi_verdict.sv
module sdi_verdict
   import sdi_pkg::*;
(
   input  sdi_step_e    step,
   input  logic [7:0]   r1,
   input  logic         nores,
   input  logic         last_try,
   output sdi_verdict_e verdict
);

   always_comb begin
      verdict = VD_FAIL;
      unique case (step)
         ST_WAKE:    verdict = VD_NEXT;
         ST_RESET:   verdict = (!nores && r1 == RSP_IDLE_ONLY) ? VD_NEXT : VD_FAIL;
         ST_IFCOND: begin
            if (nores)                        verdict = VD_FAIL;
            else if (r1 == RSP_IDLE_ONLY)     verdict = VD_NEXT;
            else if (r1 == RSP_IDLE_ILLEGAL)  verdict = VD_ALT;
            else                              verdict = VD_FAIL;
         end
         ST_APPCMD:  verdict = nores ? VD_FAIL : VD_NEXT;
         ST_OPCOND: begin
            if (nores)                  verdict = VD_FAIL;
            else if (r1 == RSP_READY)   verdict = VD_NEXT;
            else if (last_try)          verdict = VD_FAIL;
            else                        verdict = VD_RETRY;
         end
         ST_READOCR: verdict = nores ? VD_FAIL : VD_NEXT;
         ST_BLKLEN:  verdict = (!nores && r1 == RSP_READY) ? VD_NEXT : VD_FAIL;
         default:    verdict = VD_FAIL;
      endcase
   end

endmodule

// File: rtl/sdi_try_ctr.sv
module sdi_try_ctr #(
   parameter int MAX_TRIES = 5000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic bump,
   output logic last
);

   localparam int CW = (MAX_TRIES < 2) ? 1 : $clog2(MAX_TRIES);
   localparam logic [CW-1:0] LAST_VAL = CW'(MAX_TRIES - 1);

   logic [CW-1:0] count_q;

   always_ff @(posedge clk) begin
      if (!rst_n)     count_q <= '0;
      else if (clear) count_q <= '0;
      else if (bump)  count_q <= count_q + 1'b1;
   end

   assign last = (count_q == LAST_VAL);

endmodule

// File: rtl/sdi_init_seq.sv
module sdi_init_seq
   import sdi_pkg::*;
#(
   parameter int MAX_TRIES   = 5000,
   parameter int WAKE_BYTES  = 16,
   parameter int BLOCK_BYTES = 512,
   parameter int CCS_BIT     = 30
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 start,
   output logic                                 busy,
   output logic                                 done,
   output logic                                 error,
   output logic [1:0]                           card_type,
   output logic                                 clk_fast,
   output logic                                 eng_req,
   output logic                                 eng_idle_clk,
   output logic [$clog2(WAKE_BYTES+1)-1:0]      eng_idle_bytes,
   output logic [5:0]                           eng_cmd,
   output logic [31:0]                          eng_arg,
   output logic [7:0]                           eng_crc,
   output logic                                 eng_long,
   input  logic                                 eng_ack,
   input  logic [7:0]                           eng_r1,
   input  logic                                 eng_nores,
   input  logic [31:0]                          eng_ocr
);

   localparam int WBW = $clog2(WAKE_BYTES + 1);

   generate
      if (MAX_TRIES < 1) begin : g_bad_tries
         $error("sdi_init_seq: MAX_TRIES must be at least 1");
      end
      if (WAKE_BYTES < 1) begin : g_bad_wake
         $error("sdi_init_seq: WAKE_BYTES must be at least 1");
      end
      if (BLOCK_BYTES < 1) begin : g_bad_blk
         $error("sdi_init_seq: BLOCK_BYTES must be at least 1");
      end
      if (CCS_BIT < 0 || CCS_BIT > 31) begin : g_bad_ccs
         $error("sdi_init_seq: CCS_BIT must lie within the 32-bit tail");
      end
   endgenerate

   sdi_step_e    step_q, step_nx;
   sdi_verdict_e vd;
   sdi_req_t     req;
   logic         v2_q, hc_q;
   logic         start_ok, bump, last_try;
   logic         unused_ocr_bits;

   assign busy     = (step_q != ST_IDLE);
   assign start_ok = (step_q == ST_IDLE) && start;
   assign bump     = eng_ack && (step_q == ST_OPCOND) && (vd == VD_RETRY);

   assign unused_ocr_bits = ^eng_ocr;

   sdi_req_gen #(.BLOCK_BYTES(BLOCK_BYTES)) u_req (
      .step (step_q),
      .req  (req)
   );

   sdi_verdict u_vd (
      .step     (step_q),
      .r1       (eng_r1),
      .nores    (eng_nores),
      .last_try (last_try),
      .verdict  (vd)
   );

   sdi_try_ctr #(.MAX_TRIES(MAX_TRIES)) u_try (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (start_ok),
      .bump  (bump),
      .last  (last_try)
   );

   assign eng_req        = busy;
   assign eng_idle_clk   = req.dummy;
   assign eng_idle_bytes = req.dummy ? WBW'(WAKE_BYTES) : '0;
   assign eng_cmd        = req.idx;
   assign eng_arg        = req.arg;
   assign eng_crc        = req.crc;
   assign eng_long       = req.long_rsp;

   always_comb begin
      step_nx = ST_IDLE;
      unique case (step_q)
         ST_WAKE:    step_nx = ST_RESET;
         ST_RESET:   step_nx = ST_IFCOND;
         ST_IFCOND:  step_nx = ST_APPCMD;
         ST_APPCMD:  step_nx = ST_OPCOND;
         ST_OPCOND:  step_nx = (vd == VD_RETRY) ? ST_APPCMD
                              : (v2_q ? ST_READOCR : ST_BLKLEN);
         ST_READOCR: step_nx = ST_BLKLEN;
         default:    step_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         step_q    <= ST_IDLE;
         done      <= 1'b0;
         error     <= 1'b0;
         card_type <= TYPE_NONE;
         clk_fast  <= 1'b0;
         v2_q      <= 1'b0;
         hc_q      <= 1'b0;
      end else if (start_ok) begin
         step_q    <= ST_WAKE;
         done      <= 1'b0;
         error     <= 1'b0;
         card_type <= TYPE_NONE;
         clk_fast  <= 1'b0;
         v2_q      <= 1'b0;
         hc_q      <= 1'b0;
      end else if (busy && eng_ack) begin
         if (vd == VD_FAIL) begin
            step_q    <= ST_IDLE;
            error     <= 1'b1;
            card_type <= TYPE_NONE;
         end else if (step_q == ST_BLKLEN) begin
            step_q    <= ST_IDLE;
            done      <= 1'b1;
            clk_fast  <= 1'b1;
            card_type <= !v2_q ? TYPE_V1 : (hc_q ? TYPE_V2HC : TYPE_V2SC);
         end else begin
            step_q <= step_nx;
            if (step_q == ST_IFCOND)  v2_q <= (vd == VD_NEXT);
            if (step_q == ST_READOCR) hc_q <= eng_ocr[CCS_BIT];
         end
      end
   end

endmodule

// File: rtl/sdi_init_chk.sv
module sdi_init_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        start,
   input logic        busy,
   input logic        done,
   input logic        error,
   input logic [1:0]  card_type,
   input logic        clk_fast,
   input logic        eng_req,
   input logic        eng_idle_clk,
   input logic [5:0]  eng_cmd,
   input logic [31:0] eng_arg,
   input logic        eng_ack
);

   a_r1_busy_no_flags: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (!done && !error));

   a_r2_wake_first: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start) |=> (busy && eng_req && eng_idle_clk));

   a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_req && !eng_ack) |=> (eng_req && $stable(eng_cmd) && $stable(eng_arg)
                                 && $stable(eng_idle_clk)));

   a_r9_fast_after_done: assert property (@(posedge clk) disable iff (!rst_n)
      clk_fast |-> (!busy && done));

   a_r10_fail_type_zero: assert property (@(posedge clk) disable iff (!rst_n)
      error |-> (card_type == 2'd0));

   a_r10_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && error));

   a_r10_outcome_held: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> ($stable(done) && $stable(error) && $stable(card_type)
                             && $stable(clk_fast)));

endmodule

bind sdi_init_seq sdi_init_chk u_chk (.*);

// File: tb/sim_sdi_init_seq.sv
module sim_sdi_init_seq;

   localparam int TRIES = 3;
   localparam int WB    = 16;
   localparam int WBW   = $clog2(WB + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic busy, done, error, clk_fast, eng_req, eng_idle_clk, eng_long;
   logic [1:0]     card_type;
   logic [WBW-1:0] eng_idle_bytes;
   logic [5:0]     eng_cmd;
   logic [31:0]    eng_arg;
   logic [7:0]     eng_crc;
   logic           eng_ack = 1'b0;
   logic [7:0]     eng_r1 = 8'hFF;
   logic           eng_nores = 1'b0;
   logic [31:0]    eng_ocr = '0;

   always #2 clk = ~clk;

   sdi_init_seq #(.MAX_TRIES(TRIES), .WAKE_BYTES(WB)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
      .error(error), .card_type(card_type), .clk_fast(clk_fast),
      .eng_req(eng_req), .eng_idle_clk(eng_idle_clk), .eng_idle_bytes(eng_idle_bytes),
      .eng_cmd(eng_cmd), .eng_arg(eng_arg), .eng_crc(eng_crc), .eng_long(eng_long),
      .eng_ack(eng_ack), .eng_r1(eng_r1), .eng_nores(eng_nores), .eng_ocr(eng_ocr)
   );

   typedef struct {
      string       tag;
      bit          dummy;
      int          cmd;
      logic [31:0] arg;
      logic [7:0]  crc;
      bit          lng;
      logic [7:0]  r1;
      bit          nores;
      logic [31:0] ocr;
      bit          term;
      bit          fail;
      int          typ;
   } step_t;

   step_t q[$];

   int nchk = 0, nfail = 0;
   int lat = 0, wcnt = 0, hold_start = 0;
   bit col_arm = 1'b0;
   bit e_busy = 0, e_done = 0, e_err = 0, e_fast = 0;
   int e_type = 0;

   task automatic chk(string rq, string what, logic [31:0] act, logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", rq, what, act, exp, $time);
      end
   endtask

   task automatic add(string tag, bit dummy, int cmd, logic [31:0] arg, logic [7:0] crc,
                      bit lng, logic [7:0] r1, bit nores, logic [31:0] ocr);
      step_t s;
      s.tag = tag; s.dummy = dummy; s.cmd = cmd; s.arg = arg; s.crc = crc; s.lng = lng;
      s.r1 = r1; s.nores = nores; s.ocr = ocr; s.term = 0; s.fail = 0; s.typ = 0;
      q.push_back(s);
   endtask

   task automatic finish_q(bit fail, int typ);
      q[q.size()-1].term = 1;
      q[q.size()-1].fail = fail;
      q[q.size()-1].typ  = typ;
   endtask

   // one negedge: compare model against the design, then act as the engine and driver
   task automatic tick(bit st);
      bit was_busy;
      bit term_now;
      step_t s;
      @(negedge clk);
      chk("R1",  "busy",      {31'd0, busy},    {31'd0, e_busy});
      chk("R1",  "eng_req",   {31'd0, eng_req}, {31'd0, e_busy});
      chk("R10", "done",      {31'd0, done},    {31'd0, e_done});
      chk("R10", "error",     {31'd0, error},   {31'd0, e_err});
      chk("R10", "card_type", {30'd0, card_type}, 32'(e_type));
      chk("R9",  "clk_fast",  {31'd0, clk_fast}, {31'd0, e_fast});
      was_busy = e_busy;
      term_now = 1'b0;
      if (eng_ack) begin
         eng_ack = 1'b0; eng_nores = 1'b0; eng_r1 = 8'hFF; eng_ocr = '0;
      end else if (eng_req) begin
         if (q.size() == 0) begin
            nchk++; nfail++;
            $display("FAIL R1 unexpected request: actual cmd %0d expected none", eng_cmd);
         end else if (wcnt < lat) begin
            wcnt++;
         end else begin
            s = q.pop_front();
            wcnt = 0;
            chk(s.dummy ? "R2" : s.tag, "idle_clk", {31'd0, eng_idle_clk}, {31'd0, s.dummy});
            if (s.dummy) begin
               chk("R2", "idle_bytes", 32'(eng_idle_bytes), 32'(WB));
            end else begin
               chk(s.tag, "cmd",  {26'd0, eng_cmd}, 32'(s.cmd));
               chk(s.tag, "arg",  eng_arg, s.arg);
               chk(s.tag, "crc",  {24'd0, eng_crc}, {24'd0, s.crc});
               chk(s.tag, "long", {31'd0, eng_long}, {31'd0, s.lng});
            end
            eng_ack = 1'b1; eng_r1 = s.r1; eng_nores = s.nores; eng_ocr = s.ocr;
            if (s.term) begin
               term_now = 1'b1;
               e_busy = 0; e_done = !s.fail; e_err = s.fail; e_type = s.typ; e_fast = !s.fail;
            end
         end
      end
      start = st || (col_arm && term_now);
      if (start && !was_busy) begin
         e_busy = 1; e_done = 0; e_err = 0; e_type = 0; e_fast = 0; wcnt = 0;
      end
   endtask

   task automatic run(int l, int hold, bit col);
      int n;
      lat = l; hold_start = hold; col_arm = col;
      tick(1'b1);
      n = 0;
      while ((q.size() != 0 || e_busy) && n < 3000) begin
         tick(n < hold_start);
         n++;
      end
      if (n >= 3000) begin
         nchk++; nfail++;
         $display("FAIL R1 run did not complete: actual busy expected idle");
      end
      col_arm = 1'b0;
      for (int i = 0; i < 4; i++) tick(1'b0);
   endtask

   task automatic pre();
      add("R2", 1, 0, 32'h0, 8'h00, 0, 8'hFF, 0, 32'h0);
   endtask
   task automatic c0(logic [7:0] r);       add("R3", 0, 0, 32'h0, 8'h95, 0, r, 0, 32'h0); endtask
   task automatic c8(logic [7:0] r, bit nr); add("R4", 0, 8, 32'h1AA, 8'h87, 1, r, nr, 32'h0); endtask
   task automatic c55(logic [7:0] r, bit nr); add("R5", 0, 55, 32'h0, 8'hFF, 0, r, nr, 32'h0); endtask
   task automatic c41(logic [7:0] r);      add("R5", 0, 41, 32'h0, 8'hFF, 0, r, 0, 32'h0); endtask
   task automatic c58(logic [31:0] o);     add("R7", 0, 58, 32'h0, 8'hFF, 1, 8'h00, 0, o); endtask
   task automatic c16(logic [7:0] r);      add("R8", 0, 16, 32'd512, 8'hFF, 0, r, 0, 32'h0); endtask

   initial begin
      #(4 * 150000);
      nfail++;
      $display("FAIL R1 watchdog expired: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      tick(1'b0);   // reset state: all flags low (R1, R9, R10)

      // second generation, high capacity, one retry (R5, R7)
      pre(); c0(8'h01); c8(8'h01, 0); c55(8'h01, 0); c41(8'h01); c55(8'h01, 0); c41(8'h00);
      c58(32'hC0FF_8000); c16(8'h00); finish_q(0, 3);
      run(0, 0, 0);

      // second generation, standard capacity; start held while busy (R1); r1 of 55 ignored (R5)
      pre(); c0(8'h01); c8(8'h01, 0); c55(8'h7F, 0); c41(8'h00);
      c58(32'h80FF_8000); c16(8'h00); finish_q(0, 2);
      run(2, 6, 0);

      // first generation, no 58 step (R7); start collides with final acknowledge (R1)
      pre(); c0(8'h01); c8(8'h05, 0); c55(8'h01, 0); c41(8'h01); c55(8'h01, 0); c41(8'h00);
      c16(8'h00); finish_q(0, 1);
      run(1, 0, 1);

      // reset response not exactly 0x01 (R3)
      pre(); c0(8'h00); finish_q(1, 0);
      run(0, 0, 0);
      pre(); c0(8'h03); finish_q(1, 0);
      run(1, 0, 0);

      // interface check with unknown response (R4)
      pre(); c0(8'h01); c8(8'h04, 0); finish_q(1, 0);
      run(0, 0, 0);

      // retry limit exhausted (R6)
      pre(); c0(8'h01); c8(8'h01, 0);
      for (int i = 0; i < TRIES; i++) begin c55(8'h01, 0); c41(8'h01); end
      finish_q(1, 0);
      run(1, 0, 1);

      // success on the last permitted attempt (R6)
      pre(); c0(8'h01); c8(8'h01, 0);
      for (int i = 0; i < TRIES - 1; i++) begin c55(8'h01, 0); c41(8'h01); end
      c55(8'h01, 0); c41(8'h00); c58(32'h0000_0000); c16(8'h00); finish_q(0, 2);
      run(0, 0, 0);

      // block length rejected: error, slow clock kept (R8, R9)
      pre(); c0(8'h01); c8(8'h05, 0); c55(8'h01, 0); c41(8'h00); c16(8'h20); finish_q(1, 0);
      run(2, 0, 0);

      // missing responses (R11)
      pre(); c0(8'h01); c8(8'h01, 1); finish_q(1, 0);
      run(0, 0, 0);
      pre(); c0(8'h01); c8(8'h01, 0); c55(8'h00, 1); finish_q(1, 0);
      run(1, 0, 0);

      // final good run leaves fast clock selected (R9)
      pre(); c0(8'h01); c8(8'h05, 0); c55(8'h01, 0); c41(8'h00); c16(8'h00); finish_q(0, 1);
      run(0, 0, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

endmodule